// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a bank of level-sensitive interrupt request lines and gates each one with its own enable bit. Every asserted and enabled line contributes to a single registered interrupt output toward the processor. Alongside that, a set of numbered vector slots steers chosen sources to handler addresses. Each slot holds an enable bit, a source selector and a stored handler address. When several slots are live, the slot with the lowest number has priority.

The processor's interrupt entry code reads the current-vector register. That read returns the handler address of the winning slot, or a programmable fallback address when no slot is live. The value read is then frozen. Later reads return the same address, even if a request of higher priority arrives while the handler runs. The freeze lasts until the handler's closing write to the current-vector register, which acts as the acknowledge.

Configuration and status sit behind a single-cycle register port. Writes take effect at the clock edge where the write strobe is high. Read data appears on the clock edge that samples the read strobe and is then held. All offsets are word offsets on a 7-bit address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0. The enable mask, the fallback address and every slot control field read as 0.
- R2: Offset 0x00 returns the request lines as sampled one clock earlier, with no regard to the enable mask. Offset 0x01 returns those same sampled lines ANDed with the enable mask.
- R3: A write to offset 0x02 ORs the data into the enable mask and clears no bit. A write to offset 0x03 clears each mask bit whose data bit is 1. A read of either offset returns the mask. Bit n of the mask belongs to source n.
- R4: `irq_o` is 1 exactly one clock after the masked status (offset 0x01) is nonzero, and 0 one clock after it is zero.
- R5: The control field of slot i sits at offset 0x60+i. Bit 5 is the slot enable, bits 4:0 select the source, and the field reads back as written. A slot whose bit 5 is 0 never wins arbitration.
- R6: The handler address of slot i sits at offset 0x40+i and reads back as written.
- R7: A slot is live when its enable bit is set and its selected source is both asserted and enabled in the mask. A read of offset 0x05 returns the address of the lowest-numbered live slot. A slot whose source is masked off never wins. A request that changes in the same cycle as the read does not affect the value returned.
- R8: When no slot is live, a read of offset 0x05 returns the fallback address, which is written and read at offset 0x04.
- R9: The first read of offset 0x05 freezes the returned value. Every later read returns the frozen value until an acknowledge, even if a higher-priority slot has become live in the meantime.
- R10: Any write to offset 0x05 is an acknowledge and releases the frozen value, so the next read arbitrates afresh. This holds when a new request rises in the acknowledge's own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_SRC | Level-sensitive request lines, bit n is source n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 7 | Register word offset |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, registered |
| irq_o | output | 1 | Interrupt request to the processor, registered |

## Verification
The acknowledge write and the arrival of a request of higher priority can land in the same clock cycle. The bench provokes this by raising the new source on the exact edge of the acknowledge. It then checks that the next read of the current vector returns the new winner's address rather than the released one. A second pairing, a current-vector read in the cycle where a higher-priority source rises, is also driven. It must return the older winner and keep that value frozen across a further read, until the acknowledge. Both cases are judged against a bench model of masks, slots and the freeze flag, under seeded random traffic.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int REG_AW       = 7;
  localparam int SLOT_FIELD_W = 5;

  localparam logic [REG_AW-1:0] OFS_RAW       = 7'h00;
  localparam logic [REG_AW-1:0] OFS_MASKED    = 7'h01;
  localparam logic [REG_AW-1:0] OFS_EN_SET    = 7'h02;
  localparam logic [REG_AW-1:0] OFS_EN_CLR    = 7'h03;
  localparam logic [REG_AW-1:0] OFS_DEFAULT   = 7'h04;
  localparam logic [REG_AW-1:0] OFS_CURRENT   = 7'h05;
  localparam logic [REG_AW-1:0] OFS_SLOT_ADDR = 7'h40;
  localparam logic [REG_AW-1:0] OFS_SLOT_CTRL = 7'h60;
endpackage

// File: rtl/irq_src_mask.sv
module irq_src_mask #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wbits_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] masked_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] en_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= irq_src_i;
      if (set_we)      en_q <= en_q | wbits_i;
      else if (clr_we) en_q <= en_q & ~wbits_i;
      irq_q <= |(raw_q & en_q);
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = irq_q;

  // R3: a set write never drops a bit already in the mask
  a_r3_set_keeps: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R3: a clear write never adds a bit
  a_r3_clr_only_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((en_q & ~$past(en_q)) == '0));

  // R4: the output follows the masked status one clock later
  a_r4_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|masked_o) |=> irq_o);
  a_r4_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|masked_o) |=> !irq_o);
endmodule

// File: rtl/irq_slot_bank.sv
module irq_slot_bank #(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  parameter int DW       = 32,
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int CTRL_W  = $clog2(NUM_SRC) + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           addr_we,
  input  logic                           ctrl_we,
  input  logic [SLOT_W-1:0]              wr_idx,
  input  logic [DW-1:0]                  wdata_i,
  input  logic [SLOT_W-1:0]              rd_idx,
  input  logic [SLOT_W-1:0]              win_idx,
  output logic [NUM_SLOT-1:0][CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]                  bus_addr_o,
  output logic [DW-1:0]                  win_addr_o
);
  // handler addresses: plain memory, no reset, so it maps to distributed RAM
  logic [DW-1:0] vec_mem [NUM_SLOT];

  always_ff @(posedge clk) begin
    if (addr_we) vec_mem[wr_idx] <= wdata_i;
  end

  assign bus_addr_o = vec_mem[rd_idx];
  assign win_addr_o = vec_mem[win_idx];

  // control fields: flops, all visible at once to the arbiter
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_o[g] <= '0;
      else if (ctrl_we && (wr_idx == SLOT_W'(g)))
        ctrl_o[g] <= wdata_i[CTRL_W-1:0];
    end
  end

  // R5: a control write lands in the addressed slot
  a_r5_ctrl_store: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (ctrl_o[$past(wr_idx)] == $past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/irq_slot_arb.sv
module irq_slot_arb #(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int CTRL_W  = SEL_W + 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SLOT-1:0][CTRL_W-1:0] ctrl_i,
  input  logic [NUM_SRC-1:0]              masked_i,
  output logic                            win_vld_o,
  output logic [SLOT_W-1:0]               win_idx_o
);
  logic [NUM_SLOT-1:0] live;
  logic                nxt_vld;
  logic [SLOT_W-1:0]   nxt_idx;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_live
    assign live[g] = ctrl_i[g][CTRL_W-1] & masked_i[ctrl_i[g][SEL_W-1:0]];
  end

  always_comb begin
    nxt_vld = 1'b0;
    nxt_idx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (live[i]) begin
        nxt_vld = 1'b1;
        nxt_idx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_vld_o <= 1'b0;
      win_idx_o <= '0;
    end else begin
      win_vld_o <= nxt_vld;
      win_idx_o <= nxt_idx;
    end
  end

  // checking copy of the live vector, one clock behind
  logic [NUM_SLOT-1:0] live_q;
  logic [NUM_SLOT-1:0] below_win;
  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= live;
  end
  assign below_win = ({{(NUM_SLOT-1){1'b0}}, 1'b1} << win_idx_o) - {{(NUM_SLOT-1){1'b0}}, 1'b1};

  // R7: the winner was live and no lower-numbered slot was
  a_r7_winner_lowest: assert property (@(posedge clk) disable iff (rst)
    win_vld_o |-> (live_q[win_idx_o] && ((live_q & below_win) == '0)));

  // R8: no winner only when nothing was live
  a_r8_no_winner_idle: assert property (@(posedge clk) disable iff (rst)
    !win_vld_o |-> (live_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o
);
  localparam int SLOT_W = $clog2(NUM_SLOT);
  localparam int CTRL_W = $clog2(NUM_SRC) + 1;

  // register decode
  logic              slot_in_range;
  logic              hit_addr, hit_ctrl;
  logic [SLOT_W-1:0] bus_idx;
  logic              set_we, clr_we, dflt_we, ack_we, cur_rd;

  assign slot_in_range = int'(bus_addr_i[SLOT_FIELD_W-1:0]) < NUM_SLOT;
  assign hit_addr = (bus_addr_i[REG_AW-1:SLOT_FIELD_W] == OFS_SLOT_ADDR[REG_AW-1:SLOT_FIELD_W]) && slot_in_range;
  assign hit_ctrl = (bus_addr_i[REG_AW-1:SLOT_FIELD_W] == OFS_SLOT_CTRL[REG_AW-1:SLOT_FIELD_W]) && slot_in_range;
  assign bus_idx  = bus_addr_i[SLOT_W-1:0];
  assign set_we   = bus_wr_i && (bus_addr_i == OFS_EN_SET);
  assign clr_we   = bus_wr_i && (bus_addr_i == OFS_EN_CLR);
  assign dflt_we  = bus_wr_i && (bus_addr_i == OFS_DEFAULT);
  assign ack_we   = bus_wr_i && (bus_addr_i == OFS_CURRENT);
  assign cur_rd   = bus_rd_i && (bus_addr_i == OFS_CURRENT);

  // request sampling and masking
  logic [NUM_SRC-1:0] raw, en, masked;

  irq_src_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .irq_src_i(irq_src_i),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wbits_i  (bus_wdata_i[NUM_SRC-1:0]),
    .raw_o    (raw),
    .en_o     (en),
    .masked_o (masked),
    .irq_o    (irq_o)
  );

  // vector slots
  logic [NUM_SLOT-1:0][CTRL_W-1:0] ctrl_all;
  logic [DW-1:0]                   slot_rd_addr, win_addr;
  logic                            win_vld;
  logic [SLOT_W-1:0]               win_idx;

  irq_slot_bank #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .addr_we   (bus_wr_i && hit_addr),
    .ctrl_we   (bus_wr_i && hit_ctrl),
    .wr_idx    (bus_idx),
    .wdata_i   (bus_wdata_i),
    .rd_idx    (bus_idx),
    .win_idx   (win_idx),
    .ctrl_o    (ctrl_all),
    .bus_addr_o(slot_rd_addr),
    .win_addr_o(win_addr)
  );

  irq_slot_arb #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .ctrl_i   (ctrl_all),
    .masked_i (masked),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx)
  );

  // fallback address and frozen current vector
  logic [DW-1:0] dflt_q, cur_q, fresh;
  logic          held_q;

  assign fresh = win_vld ? win_addr : dflt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_q <= '0;
      cur_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (dflt_we) dflt_q <= bus_wdata_i;
      if (cur_rd && !held_q) begin
        cur_q  <= fresh;
        held_q <= 1'b1;
      end
      if (ack_we) held_q <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      if (hit_addr)      bus_rdata_o <= slot_rd_addr;
      else if (hit_ctrl) bus_rdata_o <= DW'(ctrl_all[bus_idx]);
      else begin
        case (bus_addr_i)
          OFS_RAW:     bus_rdata_o <= DW'(raw);
          OFS_MASKED:  bus_rdata_o <= DW'(masked);
          OFS_EN_SET:  bus_rdata_o <= DW'(en);
          OFS_EN_CLR:  bus_rdata_o <= DW'(en);
          OFS_DEFAULT: bus_rdata_o <= dflt_q;
          OFS_CURRENT: bus_rdata_o <= held_q ? cur_q : fresh;
          default:     bus_rdata_o <= '0;
        endcase
      end
    end
  end

  // R9: a frozen vector stays put until an acknowledge
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (held_q && !ack_we) |=> (held_q && $stable(cur_q)));

  // R9: reads while frozen return the frozen value
  a_r9_read_frozen: assert property (@(posedge clk) disable iff (rst)
    (cur_rd && held_q && !ack_we) |=> (bus_rdata_o == cur_q));

  // R10: an acknowledge releases the freeze
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> !held_q);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NSRC  = 32;
  localparam int NSLOT = 16;
  localparam logic [6:0] A_RAW = 7'h00, A_MSK = 7'h01, A_SET = 7'h02, A_CLR = 7'h03;
  localparam logic [6:0] A_DEF = 7'h04, A_CUR = 7'h05, A_SADDR = 7'h40, A_SCTRL = 7'h60;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src;
  logic        wr, rd;
  logic [6:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(NSRC), .NUM_SLOT(NSLOT), .DW(32)) u_dut (
    .clk(clk), .rst(rst), .irq_src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] m_en, m_src, m_dflt, m_cur;
  bit          m_held;
  logic [5:0]  m_ctrl [NSLOT];
  logic [31:0] m_addr [NSLOT];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v; m_src = v;
    settle(3);
  endtask

  task automatic en_set(input logic [31:0] v);
    bus_write(A_SET, v); m_en = m_en | v;
  endtask

  task automatic en_clr(input logic [31:0] v);
    bus_write(A_CLR, v); m_en = m_en & ~v;
  endtask

  task automatic put_ctrl(input int i, input logic [5:0] v);
    bus_write(A_SCTRL + 7'(i), {26'b0, v}); m_ctrl[i] = v;
  endtask

  task automatic put_addr(input int i, input logic [31:0] v);
    bus_write(A_SADDR + 7'(i), v); m_addr[i] = v;
  endtask

  function automatic logic [31:0] exp_vec();
    logic [31:0] live_src;
    live_src = m_src & m_en;
    for (int i = 0; i < NSLOT; i++) begin
      if (m_ctrl[i][5] && live_src[m_ctrl[i][4:0]]) return m_addr[i];
    end
    return m_dflt;
  endfunction

  task automatic chk_cur(input string tag);
    logic [31:0] d, e;
    settle(2);
    bus_read(A_CUR, d);
    e = m_held ? m_cur : exp_vec();
    check(tag, d, e);
    m_held = 1; m_cur = e;
  endtask

  task automatic ack();
    bus_write(A_CUR, 32'h0); m_held = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    r = $urandom(32'h5eed_1234);
    rst = 1'b1; src = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
    m_en = 0; m_src = 0; m_dflt = 0; m_cur = 0; m_held = 0;
    for (int i = 0; i < NSLOT; i++) begin m_ctrl[i] = 0; m_addr[i] = 0; end
    settle(4);
    rst = 1'b0;
    settle(1);

    // R1: reset state
    check("R1 irq_o after reset", {31'b0, irq}, 32'h0);
    bus_read(A_SET, d);           check("R1 enable mask after reset", d, 32'h0);
    bus_read(A_DEF, d);           check("R1 fallback after reset", d, 32'h0);
    bus_read(A_SCTRL + 7'd3, d);  check("R1 slot3 ctrl after reset", d, 32'h0);
    bus_read(A_SCTRL + 7'd15, d); check("R1 slot15 ctrl after reset", d, 32'h0);

    // R6: program every slot address and read some back
    for (int i = 0; i < NSLOT; i++) put_addr(i, 32'h0000_1000 + 32'(i) * 32'h40);
    bus_read(A_SADDR + 7'd5, d);  check("R6 slot5 address", d, 32'h0000_1140);
    bus_read(A_SADDR + 7'd15, d); check("R6 slot15 address", d, 32'h0000_13c0);

    // R2: raw and masked status with empty mask
    drive_src(32'ha5a5_0f0f);
    bus_read(A_RAW, d); check("R2 raw status", d, 32'ha5a5_0f0f);
    bus_read(A_MSK, d); check("R2 masked status empty mask", d, 32'h0);
    check("R4 irq_o low with empty mask", {31'b0, irq}, 32'h0);

    // R3: set never clears, clear only clears
    en_set(32'h0000_00f0);
    en_set(32'h0001_0000);
    bus_read(A_SET, d); check("R3 mask after two set writes", d, 32'h0001_00f0);
    en_clr(32'h0000_0010);
    bus_read(A_CLR, d); check("R3 mask after clear write", d, 32'h0001_00e0);
    settle(2);
    bus_read(A_MSK, d); check("R2 masked status", d, 32'ha5a5_0f0f & 32'h0001_00e0);
    check("R4 irq_o high", {31'b0, irq}, 32'h1);
    en_clr(32'hffff_ffff);
    settle(2);
    check("R4 irq_o drops", {31'b0, irq}, 32'h0);

    // R5: slot control layout and readback
    put_ctrl(0, 6'h04);          // enable bit clear, source 4
    put_ctrl(1, 6'h20 | 6'd4);
    put_ctrl(2, 6'h20 | 6'd17);
    put_ctrl(3, 6'h20 | 6'd9);
    bus_read(A_SCTRL + 7'd2, d); check("R5 slot2 ctrl readback", d, 32'h31);
    bus_read(A_SCTRL + 7'd0, d); check("R5 slot0 ctrl readback", d, 32'h04);
    bus_write(A_DEF, 32'hdead_0000); m_dflt = 32'hdead_0000;
    bus_read(A_DEF, d); check("R8 fallback readback", d, 32'hdead_0000);

    en_set((32'h1 << 4) | (32'h1 << 17) | (32'h1 << 9));
    drive_src(32'h1 << 17);
    chk_cur("R7 single live slot2");
    ack();
    drive_src((32'h1 << 4) | (32'h1 << 17));
    chk_cur("R5 disabled slot0 skipped, slot1 wins");
    check("R5 slot1 address expected", m_cur, 32'h0000_1040);
    ack();
    en_clr(32'h1 << 4);
    chk_cur("R7 masked source loses, slot2 wins");
    ack();

    // R8: nothing live gives fallback
    drive_src(32'h0);
    chk_cur("R8 fallback when idle");
    ack();

    // R9: freeze across a higher-priority arrival
    en_set(32'h1 << 4);
    drive_src(32'h1 << 17);
    chk_cur("R9 first read slot2");
    drive_src((32'h1 << 17) | (32'h1 << 4));
    chk_cur("R9 frozen despite slot1");
    check("R9 frozen is slot2 address", m_cur, 32'h0000_1080);
    ack();
    chk_cur("R10 after ack slot1");

    // R10: acknowledge and new request in the same cycle
    drive_src(32'h1 << 17);   // still frozen on slot1
    @(negedge clk);
    wr = 1'b1; addr = A_CUR; wdata = 32'h0;
    src = (32'h1 << 17) | (32'h1 << 9) | (32'h1 << 4);
    m_src = src;
    @(negedge clk);
    wr = 1'b0;
    m_held = 0;
    chk_cur("R10 same-cycle ack and rise");
    check("R10 new winner slot1", m_cur, 32'h0000_1040);
    ack();

    // R7: read in the cycle a higher-priority request rises
    drive_src(32'h1 << 17);
    settle(2);
    @(negedge clk);
    rd = 1'b1; addr = A_CUR;
    src = (32'h1 << 17) | (32'h1 << 4);
    m_src = src;
    @(negedge clk);
    rd = 1'b0;
    check("R7 same-cycle rise keeps older winner", rdata, 32'h0000_1080);
    m_held = 1; m_cur = 32'h0000_1080;
    chk_cur("R9 still frozen after late rise");
    ack();
    chk_cur("R10 re-arbitrated slot1");
    ack();

    // random traffic
    for (int it = 0; it < 120; it++) begin
      r = $urandom;
      case (r % 4)
        0: en_set($urandom);
        1: en_clr($urandom);
        2: put_ctrl(int'($urandom % NSLOT), 6'($urandom));
        default: ;
      endcase
      drive_src($urandom & $urandom & $urandom);
      bus_read(A_MSK, d); check("R2 random masked status", d, m_src & m_en);
      check("R4 random irq_o", {31'b0, irq}, {31'b0, |(m_src & m_en)});
      chk_cur("R7 random arbitration");
      if (r[4]) begin
        drive_src($urandom & $urandom);
        chk_cur("R9 random frozen read");
      end
      ack();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule